// File: doc/BRIEF.md
# Non-volatile SRAM store/recall controller

This block is the control logic of a non-volatile SRAM. It holds a working SRAM array and a shadow copy that stands in for the non-volatile cells. It copies the array into the shadow (STORE) or the shadow back into the array (RECALL), and it gates SRAM reads and writes while it does so.

A STORE is requested over one shared open-drain line. The requester pulls the line low. While a STORE runs, the block pulls the same line low itself to signal that it is busy. The line is modelled as a sampled input (`req_line_i`, 1 = line high) plus an output enable (`busy_oe_o`); the wired-AND is left to the surrounding logic. A STORE is skipped when nothing has been written since the last STORE or RECALL. A digital supply-good flag decides when a RECALL runs, and it inhibits STOREs and writes while it is low. Every duration is a cycle-count parameter.

The strobes `cs_ni` and `we_ni` are active low. A read is `cs_ni`=0 with `we_ni`=1. A write is `cs_ni`=0 with `we_ni`=0, and it updates the addressed word at the clock edge.

Top module: `nvsram_ctrl`

## Requirements
- R1: When the request line is low at the end of the pre-store window and no write has been accepted since the last completed STORE or RECALL, no STORE runs. `busy_oe_o` stays 0 and the shadow keeps its contents.
- R2: A STORE request is taken in the idle state when the request line is sampled low. The block then waits DELAY_CYC cycles before the STORE starts, so `busy_oe_o` rises DELAY_CYC+1 cycles after the first low sample. During that window reads return array data with `rdy_o`=1, and a write whose strobes were already active in the previous cycle keeps writing.
- R3: A write whose strobes become active after the request was taken is discarded until the request line has returned high. This covers writes in the pre-store window and while the line is held low after a skipped STORE.
- R4: During a STORE, `busy_oe_o` is 1 for exactly STORE_CYC cycles and no write is accepted. At completion the shadow equals the array.
- R5: After a STORE completes, `rdy_o` is 0 and no access takes effect until the request line is sampled high. `rdy_o` is 1 one cycle after that sample.
- R6: Reset, like any fall of `pwr_ok_i`, latches a RECALL. The block waits with `rdy_o`=1 while the supply is low. The cycle after `pwr_ok_i` is sampled high, a RECALL of RECALL_CYC cycles with `rdy_o`=0 starts. It ends with the array equal to the shadow.
- R7: While `pwr_ok_i` is low, writes are discarded and a low request line starts no STORE. Reads remain available.
- R8: If `cs_ni` and `we_ni` are both 0 in the last cycle of a RECALL or STORE, no write is accepted until one of them shows a fresh 1-to-0 transition.
- R9: While `rdy_o` is 0, `rdata_o` is 0 and no access takes effect.
- R10: Each accepted write marks the array dirty. A completed STORE or RECALL clears the mark, which decides between R1 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_ok_i | input | 1 | Supply above threshold |
| req_line_i | input | 1 | Sampled level of the shared request/busy line (0 = low) |
| busy_oe_o | output | 1 | Pulls the shared line low while a STORE runs |
| cs_ni | input | 1 | Chip select strobe, active low |
| we_ni | input | 1 | Write enable strobe, active low |
| addr_i | input | AW | Word address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, 0 when not reading or not ready |
| rdy_o | output | 1 | Array accessible |

## Verification
The assertions assume that `req_line_i` and the strobes are already synchronous to `clk_i`. They also assume that the request line reflects the block's own pull-down in the same cycle, as wired-AND logic would. Every cycle parameter must be at least 1. The bench changes every input on the falling clock edge. It builds the request line as the AND of its own requester and `busy_oe_o`, and it holds the parameters at small fixed values. This keeps the line consistent with the block's driver and keeps every window short enough to step through cycle by cycle.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    ST_PWR_WAIT = 3'd0,
    ST_RECALL   = 3'd1,
    ST_IDLE     = 3'd2,
    ST_DELAY    = 3'd3,
    ST_STORE    = 3'd4,
    ST_HOLD     = 3'd5,
    ST_REQ_WAIT = 3'd6
  } nvs_state_e;
endpackage

// File: rtl/nvs_seq.sv
module nvs_seq
  import nvs_pkg::*;
#(
  parameter int DELAY_CYC  = 4,
  parameter int STORE_CYC  = 5,
  parameter int RECALL_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_ok_i,
  input  logic       line_i,
  input  logic       dirty_i,
  output nvs_state_e state_o,
  output logic       store_go_o,
  output logic       recall_go_o,
  output logic       op_done_o
);
  localparam int MAXC = (DELAY_CYC > STORE_CYC)
                        ? ((DELAY_CYC > RECALL_CYC) ? DELAY_CYC : RECALL_CYC)
                        : ((STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] STO_LAST = CNT_W'(STORE_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(RECALL_CYC - 1);

  nvs_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic timed;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PWR_WAIT: if (pwr_ok_i) state_d = ST_RECALL;
      ST_RECALL:   if (cnt_q == REC_LAST) state_d = ST_IDLE;
      ST_IDLE:     if (!line_i) state_d = ST_DELAY;
      ST_DELAY:    if (cnt_q == DLY_LAST) state_d = dirty_i ? ST_STORE : ST_REQ_WAIT;
      ST_STORE:    if (cnt_q == STO_LAST) state_d = ST_HOLD;
      ST_HOLD,
      ST_REQ_WAIT: if (line_i) state_d = ST_IDLE;
      default:     state_d = ST_PWR_WAIT;
    endcase
    // supply loss aborts everything and latches a recall
    if (!pwr_ok_i) state_d = ST_PWR_WAIT;
  end

  assign timed = (state_q == ST_RECALL) || (state_q == ST_DELAY) || (state_q == ST_STORE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PWR_WAIT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) cnt_q <= '0;
      else if (timed)         cnt_q <= cnt_q + 1'b1;
    end
  end

  assign store_go_o  = pwr_ok_i && (state_q == ST_STORE)  && (cnt_q == STO_LAST);
  assign recall_go_o = pwr_ok_i && (state_q == ST_RECALL) && (cnt_q == REC_LAST);
  assign op_done_o   = store_go_o || recall_go_o;
  assign state_o     = state_q;

  AST_PWR_DROP_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_ok_i) |=> (state_q == ST_PWR_WAIT)); // R6
  AST_HOLD_UNTIL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && !line_i) |=> (state_q == ST_HOLD || state_q == ST_PWR_WAIT)); // R5
  AST_OP_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(store_go_o && recall_go_o)); // R4
endmodule

// File: rtl/nvs_wr_gate.sv
module nvs_wr_gate
  import nvs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       we_ni,
  input  logic       pwr_ok_i,
  input  nvs_state_e state_i,
  input  logic       op_done_i,
  output logic       wr_en_o,
  output logic       rd_en_o,
  output logic       rdy_o,
  output logic       dirty_o
);
  logic cs_q, we_q, lock_q, wr_acc_q, dirty_q;
  logic fall, both_low, lock_eff, state_wr_ok;

  assign both_low = !cs_ni && !we_ni;
  assign fall     = (cs_q && !cs_ni) || (we_q && !we_ni);
  assign lock_eff = lock_q && !fall;

  always_comb begin
    unique case (state_i)
      ST_IDLE:  state_wr_ok = 1'b1;
      ST_DELAY: state_wr_ok = wr_acc_q; // only a write already under way may finish
      default:  state_wr_ok = 1'b0;
    endcase
  end

  assign rdy_o   = (state_i == ST_PWR_WAIT) || (state_i == ST_IDLE) ||
                   (state_i == ST_DELAY)    || (state_i == ST_REQ_WAIT);
  assign wr_en_o = pwr_ok_i && state_wr_ok && both_low && !lock_eff;
  assign rd_en_o = rdy_o && !cs_ni && we_ni;
  assign dirty_o = dirty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q     <= 1'b1;
      we_q     <= 1'b1;
      lock_q   <= 1'b0;
      wr_acc_q <= 1'b0;
      dirty_q  <= 1'b0;
    end else begin
      cs_q     <= cs_ni;
      we_q     <= we_ni;
      wr_acc_q <= wr_en_o;
      if (op_done_i)  lock_q <= both_low;
      else if (fall)  lock_q <= 1'b0;
      if (op_done_i)    dirty_q <= 1'b0;
      else if (wr_en_o) dirty_q <= 1'b1;
    end
  end

  AST_LOCK_AFTER_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_done_i && both_low) ##1 both_low |-> !wr_en_o); // R8
  AST_DIRTY_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_done_i |=> !dirty_q); // R10
  AST_NO_WR_LOW_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!pwr_ok_i) |-> !wr_en_o); // R7
endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          store_go_i,
  input  logic          recall_go_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q    [DEPTH];
  logic [DW-1:0] shadow_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i]    <= '0;
        shadow_q[i] <= '0;
      end
    end else begin
      if (recall_go_i) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] <= shadow_q[i];
      end else if (wr_en_i) begin
        mem_q[addr_i] <= wdata_i;
      end
      if (store_go_i) begin
        for (int i = 0; i < DEPTH; i++) shadow_q[i] <= mem_q[i];
      end
    end
  end

  assign rdata_o = rd_en_i ? mem_q[addr_i] : '0;

  AST_ONE_ARRAY_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_en_i, store_go_i, recall_go_i})); // R4
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nvs_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int DW         = 8,
  parameter int DELAY_CYC  = 4,
  parameter int STORE_CYC  = 5,
  parameter int RECALL_CYC = 4,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwr_ok_i,
  input  logic          req_line_i,
  output logic          busy_oe_o,
  input  logic          cs_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rdy_o
);
  nvs_state_e state;
  logic store_go, recall_go, op_done;
  logic wr_en, rd_en, dirty;

  nvs_seq #(
    .DELAY_CYC (DELAY_CYC),
    .STORE_CYC (STORE_CYC),
    .RECALL_CYC(RECALL_CYC)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_ok_i   (pwr_ok_i),
    .line_i     (req_line_i),
    .dirty_i    (dirty),
    .state_o    (state),
    .store_go_o (store_go),
    .recall_go_o(recall_go),
    .op_done_o  (op_done)
  );

  nvs_wr_gate i_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .we_ni    (we_ni),
    .pwr_ok_i (pwr_ok_i),
    .state_i  (state),
    .op_done_i(op_done),
    .wr_en_o  (wr_en),
    .rd_en_o  (rd_en),
    .rdy_o    (rdy_o),
    .dirty_o  (dirty)
  );

  nvs_array #(
    .DEPTH(DEPTH),
    .DW   (DW)
  ) i_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .rd_en_i    (rd_en),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .store_go_i (store_go),
    .recall_go_i(recall_go),
    .rdata_o    (rdata_o)
  );

  assign busy_oe_o = (state == ST_STORE);

  AST_STORE_NEEDS_DIRTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_oe_o) |-> $past(dirty)); // R1
  AST_NO_WR_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_oe_o |-> !wr_en); // R4
  AST_BUSY_POWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_oe_o |-> $past(pwr_ok_i)); // R7
  AST_NOT_RDY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_o |-> (rdata_o == '0 && !wr_en)); // R9
endmodule

// File: tb/test_nvsram_ctrl.sv
module test_nvsram_ctrl;
  localparam int DEPTH = 16;
  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int DLY   = 4;
  localparam int STO   = 5;
  localparam int REC   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b0;
  logic ext_req = 1'b0;
  logic cs_n = 1'b1;
  logic we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic busy_oe, rdy;
  logic [DW-1:0] rdata;
  logic line;

  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] ref_sh  [DEPTH];
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  assign line = ~(ext_req | busy_oe);

  nvsram_ctrl #(
    .DEPTH(DEPTH), .DW(DW), .DELAY_CYC(DLY), .STORE_CYC(STO), .RECALL_CYC(REC)
  ) i_nvsram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pwr_ok_i(pwr_ok), .req_line_i(line),
    .busy_oe_o(busy_oe), .cs_ni(cs_n), .we_ni(we_n), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rdy_o(rdy)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_bus();
    @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cs_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic read_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    cs_n = 1'b0; we_n = 1'b1; addr = a;
    #1 check(tag, rdata, exp);
  endtask

  // raises the supply at a falling edge and counts not-ready cycles of the recall
  task automatic power_up_recall(input string tag);
    int n_low = 0;
    int n_bad = 0;
    pwr_ok = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (rdy) break;
      n_low++;
      if (rdata !== '0) n_bad++;
    end
    check({tag, " R6 recall length"}, n_low, REC);
    check({tag, " R9 zero data while not ready"}, n_bad, 0);
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = ref_sh[i];
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check("R6 reset rdy while supply low", rdy, 1);
    check("R6 reset busy_oe", busy_oe, 0);
    read_chk(4'd3, 8'h00, "R6 reset array word");
    write_word(4'd3, 8'h77);
    read_chk(4'd3, 8'h00, "R7 write ignored with supply low");
    idle_bus();
  endtask

  task automatic t_power_up();
    @(negedge clk);
    cs_n = 1'b0; we_n = 1'b1; addr = 4'd0;
    power_up_recall("powerup");
    idle_bus();
  endtask

  task automatic t_write_read();
    for (int i = 0; i < DEPTH; i++) begin
      write_word(AW'(i), DW'(8'h11 * i + 8'h3));
      ref_mem[i] = DW'(8'h11 * i + 8'h3);
    end
    for (int i = 0; i < DEPTH; i += 5)
      read_chk(AW'(i), ref_mem[i], "R10 write then read");
    write_word(4'd7, 8'hC3);
    ref_mem[7] = 8'hC3;
    read_chk(4'd7, 8'hC3, "R10 overwrite");
    idle_bus();
  endtask

  // dirty store with a write in flight, a read and a late write in the window
  task automatic t_store_dirty();
    int n_bad = 0;
    int n_busy = 0;
    @(negedge clk);
    ext_req = 1'b1; cs_n = 1'b0; we_n = 1'b0; addr = 4'd2; wdata = 8'hA1;
    @(negedge clk); // 1
    if (busy_oe) n_bad++;
    wdata = 8'hA2;
    @(negedge clk); // 2
    if (busy_oe) n_bad++;
    cs_n = 1'b1; we_n = 1'b1;
    ref_mem[2] = 8'hA2;
    @(negedge clk); // 3
    if (busy_oe) n_bad++;
    cs_n = 1'b0; we_n = 1'b1; addr = 4'd9;
    #1 check("R2 read during pre-store window", rdata, ref_mem[9]);
    check("R2 ready during pre-store window", rdy, 1);
    @(negedge clk); // 4
    if (busy_oe) n_bad++;
    cs_n = 1'b0; we_n = 1'b0; addr = 4'd5; wdata = 8'hEE; // new write: must be dropped
    @(negedge clk); // 5
    check("R2 busy low during window", n_bad, 0);
    check("R2 busy starts after window", busy_oe, 1);
    cs_n = 1'b1; we_n = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (!busy_oe) break;
      n_busy++;
      @(negedge clk);
    end
    check("R4 store busy length", n_busy, STO);
    for (int i = 0; i < DEPTH; i++) ref_sh[i] = ref_mem[i];
    check("R5 not ready after store", rdy, 0);
    cs_n = 1'b0; we_n = 1'b1; addr = 4'd2;
    #1 check("R9 read zero while held", rdata, 0);
    @(negedge clk);
    @(negedge clk);
    check("R5 still held while line low", rdy, 0);
    ext_req = 1'b0; cs_n = 1'b1;
    @(negedge clk);
    check("R5 ready after line high", rdy, 1);
    read_chk(4'd2, 8'hA2, "R2 in-flight write completed");
    read_chk(4'd5, ref_mem[5], "R3 late write blocked");
    idle_bus();
  endtask

  task automatic t_store_clean();
    int n_busy = 0;
    int n_nrdy = 0;
    @(negedge clk);
    ext_req = 1'b1;
    for (int i = 0; i < DLY + STO + 3; i++) begin
      @(negedge clk);
      if (busy_oe) n_busy++;
      if (!rdy) n_nrdy++;
    end
    check("R1 no store when clean", n_busy, 0);
    check("R1 reads stay ready when clean", n_nrdy, 0);
    write_word(4'd11, 8'h5C);
    @(negedge clk);
    ext_req = 1'b0;
    read_chk(4'd11, ref_mem[11], "R3 write blocked while line held");
    idle_bus();
  endtask

  task automatic t_recall();
    int n_busy = 0;
    write_word(4'd2, 8'h5A); // dirty, never stored
    ref_mem[2] = 8'h5A;
    @(negedge clk);
    pwr_ok = 1'b0;
    ext_req = 1'b1;
    for (int i = 0; i < DLY + STO + 2; i++) begin
      @(negedge clk);
      if (busy_oe) n_busy++;
    end
    check("R7 no store with supply low", n_busy, 0);
    ext_req = 1'b0;
    write_word(4'd4, 8'h99);
    read_chk(4'd4, ref_mem[4], "R7 write ignored after supply drop");
    read_chk(4'd2, 8'h5A, "R7 reads available while supply low");
    cs_n = 1'b0; we_n = 1'b1; addr = 4'd2;
    power_up_recall("recall");
    read_chk(4'd2, 8'hA2, "R6 array restored from shadow");
    read_chk(4'd0, ref_sh[0], "R6 other word restored");
    idle_bus();
    // recall cleared dirty: a request now is skipped
    @(negedge clk);
    ext_req = 1'b1;
    n_busy = 0;
    for (int i = 0; i < DLY + 4; i++) begin
      @(negedge clk);
      if (busy_oe) n_busy++;
    end
    check("R10 recall clears dirty", n_busy, 0);
    ext_req = 1'b0;
    idle_bus();
  endtask

  task automatic t_lock();
    @(negedge clk);
    cs_n = 1'b0; we_n = 1'b0; addr = 4'd6; wdata = 8'h3C;
    pwr_ok = 1'b0;
    @(negedge clk);
    @(negedge clk);
    power_up_recall("lock");
    @(negedge clk);
    @(negedge clk);
    we_n = 1'b1;
    #1 check("R8 held write blocked after recall", rdata, ref_sh[6]);
    @(negedge clk);
    we_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1;
    ref_mem[6] = 8'h3C;
    read_chk(4'd6, 8'h3C, "R8 write after fresh edge");
    idle_bus();
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      ref_mem[i] = '0;
      ref_sh[i]  = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_power_up();
    t_write_read();
    t_store_dirty();
    t_store_clean();
    t_recall();
    t_lock();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule